// File: doc/BRIEF.md
# BT.656 Even-Field Triplet Capture

This block sits directly behind a video decoder that delivers an 8-bit BT.656 byte stream, one byte per clock. It watches the stream for timing reference codes and opens a capture window only for active lines of the even field. Odd-field lines and blanking lines are dropped. Inside a window, each four-byte group (Cb, Y, Cr, Y) becomes one parallel triplet. The second luma byte is discarded, so the horizontal resolution is halved: 720 pixels turn into 360 triplets.

A downstream colour converter or frame writer receives a one-cycle valid strobe with each triplet. A line-start marker comes with the first triplet of every captured line. A field-start marker comes with the first triplet after the even field leaves vertical blanking. A line ends after its full byte count. It also ends at the first 0xFF byte, because 0xFF can only open a timing reference and never appears as pixel data. A group that is cut short in this way yields nothing.

Top module: `bt656_even_capture`

## Requirements
- R1: While reset is low and after its release, `trip_valid`, `line_start` and `field_start` are 0 and the three triplet outputs are 0.
- R2: A timing reference is recognised only as 0xFF, 0x00, 0x00 followed by a status byte with bit 7 set. In that byte bit 6 is the field flag, bit 5 the blanking flag and bit 4 the end-of-line flag. Bits 3..0 are ignored, so 0x8E opens a line exactly as 0x80 does.
- R3: A line opens only on a status byte with bits 6, 5 and 4 all clear. Status bytes with bit 6 set (odd field, e.g. 0xC7) or bit 5 set (blanking, e.g. 0xAB) open no line, and the bytes that follow them produce no triplet.
- R4: After an opening status byte, data bytes arrive in the order Cb, Y, Cr, Y. For group k (bytes 4k..4k+3), `trip_cb`, `trip_y` and `trip_cr` carry bytes 4k, 4k+1 and 4k+2. `trip_valid` is high for exactly the one cycle that follows the clock edge that takes byte 4k+3.
- R5: A line accepts at most 2×PIX_PER_LINE bytes (1440 by default), which gives 360 triplets. Later bytes produce nothing until the next opening status byte.
- R6: A 0xFF byte inside an open line closes it at once. An incomplete group is never emitted, and no emitted component equals 0xFF.
- R7: `line_start` is high together with the first triplet of each captured line and with no other triplet.
- R8: `field_start` is high together with the first triplet that follows an even-field status byte with bit 5 set (any protection bits). It stays low on all later lines until the next such byte, and stays low after reset until one is seen.
- R9: While `trip_valid` is low, the three triplet outputs hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vid_byte | input | 8 | BT.656 byte stream from the decoder |
| trip_valid | output | 1 | One-cycle strobe for a new triplet |
| trip_cb | output | 8 | Blue-difference chroma of the triplet |
| trip_y | output | 8 | Luma of the triplet (first Y of the group) |
| trip_cr | output | 8 | Red-difference chroma of the triplet |
| line_start | output | 1 | Marks the first triplet of a captured line |
| field_start | output | 1 | Marks the first triplet after even-field blanking |

## Verification
The stimulus contains the following kinds of line:
- full even lines with an index-dependent byte pattern, which expose a wrong byte slot or a swapped component;
- odd-field and blanking lines, which must yield nothing;
- an opening code whose protection bits are set, which must still open a line;
- a code whose status byte lacks bit 7, which must not;
- a line cut short after ten bytes, which separates emitting a partial group from dropping it;
- a line running past 1440 bytes, which shows whether the byte limit closes the window.

Lines with and without a preceding blanking code show whether the field marker is armed and cleared at the right moments.

// File: rtl/bt656_cap_pkg.sv
package bt656_cap_pkg;

    localparam int BYTE_W  = 8;
    localparam int BIT_FLD = 6;
    localparam int BIT_VBL = 5;
    localparam int BIT_EAV = 4;
    localparam int BIT_ONE = 7;

    localparam logic [BYTE_W-1:0] CODE_HI = 8'hFF;
    localparam logic [BYTE_W-1:0] CODE_LO = 8'h00;

    // decoded timing reference, valid in the cycle of the status byte
    typedef struct packed {
        logic hit;
        logic fld;
        logic vbl;
        logic eav;
    } trc_t;

    // last three bytes of the stream, oldest in b2
    typedef struct packed {
        logic [BYTE_W-1:0] b2;
        logic [BYTE_W-1:0] b1;
        logic [BYTE_W-1:0] b0;
    } hist_t;

    typedef struct packed {
        logic [BYTE_W-1:0] cb;
        logic [BYTE_W-1:0] y;
        logic [BYTE_W-1:0] cr;
    } trip_t;

endpackage

// File: rtl/bt656_trc_detect.sv
module bt656_trc_detect
    import bt656_cap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] din,
    output trc_t              trc
);

    hist_t hist_d, hist_q;

    always_comb begin
        hist_d    = hist_q;
        hist_d.b2 = hist_q.b1;
        hist_d.b1 = hist_q.b0;
        hist_d.b0 = din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_d;
        end
    end

    // status byte is the current input; preamble comes from history
    always_comb begin
        trc.hit = (hist_q.b2 == CODE_HI) && (hist_q.b1 == CODE_LO)
               && (hist_q.b0 == CODE_LO) && din[BIT_ONE];
        trc.fld = din[BIT_FLD];
        trc.vbl = din[BIT_VBL];
        trc.eav = din[BIT_EAV];
    end

endmodule

// File: rtl/bt656_line_track.sv
module bt656_line_track
    import bt656_cap_pkg::*;
#(
    parameter int PIX_PER_LINE = 720
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] din,
    input  trc_t              trc,
    output logic              byte_en,
    output logic [1:0]        phase,
    output logic              mark_line,
    output logic              mark_field
);

    localparam int BYTES_PER_LINE = 2 * PIX_PER_LINE;
    localparam int CNT_W          = $clog2(BYTES_PER_LINE);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BYTES_PER_LINE - 1);

    typedef struct packed {
        logic             act;
        logic [CNT_W-1:0] cnt;
        logic             arm;
        logic             lpend;
        logic             fpend;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;

        // even-field timing references only
        if (trc.hit && !trc.fld) begin
            if (trc.vbl) begin
                st_d.arm = 1'b1;
            end else if (!trc.eav) begin
                st_d.act   = 1'b1;
                st_d.cnt   = '0;
                st_d.lpend = 1'b1;
                st_d.fpend = st_q.arm || st_q.fpend;
                st_d.arm   = 1'b0;
            end
        end

        if (st_q.act) begin
            if (din == CODE_HI) begin
                st_d.act = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
                if (st_q.cnt == LAST_IDX) begin
                    st_d.act = 1'b0;
                end
                if (st_q.cnt[1:0] == 2'd3) begin
                    st_d.lpend = 1'b0;
                    st_d.fpend = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign byte_en    = st_q.act && (din != CODE_HI);
    assign phase      = st_q.cnt[1:0];
    assign mark_line  = st_q.lpend;
    assign mark_field = st_q.fpend;

endmodule

// File: rtl/bt656_trip_pack.sv
module bt656_trip_pack
    import bt656_cap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] din,
    input  logic              byte_en,
    input  logic [1:0]        phase,
    input  logic              mark_line,
    input  logic              mark_field,
    output logic              out_vld,
    output trip_t             out_trip,
    output logic              out_ls,
    output logic              out_fs
);

    typedef struct packed {
        trip_t coll;
        trip_t outp;
        logic  vld;
        logic  ls;
        logic  fs;
    } pk_t;

    pk_t pk_d, pk_q;

    always_comb begin
        pk_d     = pk_q;
        pk_d.vld = 1'b0;
        pk_d.ls  = 1'b0;
        pk_d.fs  = 1'b0;
        if (byte_en) begin
            case (phase)
                2'd0: pk_d.coll.cb = din;
                2'd1: pk_d.coll.y  = din;
                2'd2: pk_d.coll.cr = din;
                2'd3: begin
                    // second luma byte is dropped; group is complete
                    pk_d.outp = pk_q.coll;
                    pk_d.vld  = 1'b1;
                    pk_d.ls   = mark_line;
                    pk_d.fs   = mark_field;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pk_q <= '0;
        end else begin
            pk_q <= pk_d;
        end
    end

    assign out_vld  = pk_q.vld;
    assign out_trip = pk_q.outp;
    assign out_ls   = pk_q.ls;
    assign out_fs   = pk_q.fs;

endmodule

// File: rtl/bt656_even_capture.sv
module bt656_even_capture
    import bt656_cap_pkg::*;
#(
    parameter int PIX_PER_LINE = 720
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] vid_byte,
    output logic       trip_valid,
    output logic [7:0] trip_cb,
    output logic [7:0] trip_y,
    output logic [7:0] trip_cr,
    output logic       line_start,
    output logic       field_start
);

    trc_t       trc;
    logic       byte_en;
    logic [1:0] phase;
    logic       mark_line;
    logic       mark_field;
    trip_t      trip;

    bt656_trc_detect u_detect (
        .clk (clk),
        .rst_n (rst_n),
        .din (vid_byte),
        .trc (trc)
    );

    bt656_line_track #(
        .PIX_PER_LINE (PIX_PER_LINE)
    ) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .din        (vid_byte),
        .trc        (trc),
        .byte_en    (byte_en),
        .phase      (phase),
        .mark_line  (mark_line),
        .mark_field (mark_field)
    );

    bt656_trip_pack u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .din        (vid_byte),
        .byte_en    (byte_en),
        .phase      (phase),
        .mark_line  (mark_line),
        .mark_field (mark_field),
        .out_vld    (trip_valid),
        .out_trip   (trip),
        .out_ls     (line_start),
        .out_fs     (field_start)
    );

    assign trip_cb = trip.cb;
    assign trip_y  = trip.y;
    assign trip_cr = trip.cr;

endmodule

// File: rtl/bt656_even_capture_chk.sv
module bt656_even_capture_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] vid_byte,
    input logic       trip_valid,
    input logic [7:0] trip_cb,
    input logic [7:0] trip_y,
    input logic [7:0] trip_cr,
    input logic       line_start,
    input logic       field_start
);

    // groups are four bytes wide, so strobes are at least four cycles apart
    p_strobe_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        trip_valid |=> !trip_valid ##1 !trip_valid ##1 !trip_valid);

    // the byte closing a group is never a reference preamble byte
    p_no_ff_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trip_valid |-> ($past(vid_byte) != 8'hFF));

    p_no_ff_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trip_valid |-> (trip_cb != 8'hFF && trip_y != 8'hFF && trip_cr != 8'hFF));

    p_line_mark_r7: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |-> trip_valid);

    p_field_mark_r8: assert property (@(posedge clk) disable iff (!rst_n)
        field_start |-> line_start);

    p_hold_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !trip_valid |-> $stable({trip_cb, trip_y, trip_cr}));

endmodule

bind bt656_even_capture bt656_even_capture_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .vid_byte    (vid_byte),
    .trip_valid  (trip_valid),
    .trip_cb     (trip_cb),
    .trip_y      (trip_y),
    .trip_cr     (trip_cr),
    .line_start  (line_start),
    .field_start (field_start)
);

// File: tb/bt656_even_capture_tb_top.sv
`timescale 1ns/1ps
module bt656_even_capture_tb_top;

    localparam int NPIX  = 720;
    localparam int NBYTE = 2 * NPIX;
    localparam int NTRIP = NPIX / 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] vid_byte = 8'h10;
    logic       trip_valid;
    logic [7:0] trip_cb, trip_y, trip_cr;
    logic       line_start, field_start;

    int n_run  = 0;
    int n_fail = 0;

    // capture log
    int         ncap = 0;
    logic [7:0] lcb [0:511];
    logic [7:0] ly  [0:511];
    logic [7:0] lcr [0:511];
    logic       lls [0:511];
    logic       lfs [0:511];
    int         hold_err = 0;
    logic [23:0] last_trip = '0;

    always #4 clk = ~clk;

    bt656_even_capture #(.PIX_PER_LINE(NPIX)) dut_i (
        .clk (clk), .rst_n (rst_n), .vid_byte (vid_byte),
        .trip_valid (trip_valid), .trip_cb (trip_cb), .trip_y (trip_y),
        .trip_cr (trip_cr), .line_start (line_start), .field_start (field_start)
    );

    // sample 2 ns after each rising edge
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            if (trip_valid) begin
                if (ncap < 512) begin
                    lcb[ncap] = trip_cb; ly[ncap] = trip_y; lcr[ncap] = trip_cr;
                    lls[ncap] = line_start; lfs[ncap] = field_start;
                end
                ncap++;
                last_trip = {trip_cb, trip_y, trip_cr};
            end else if ({trip_cb, trip_y, trip_cr} != last_trip) begin
                hold_err++;
            end
        end
    end

    initial begin
        #(8 * 200000);
        n_run++; n_fail++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    function automatic logic [7:0] pix(input int ln, input int i);
        return 8'(16 + ((i * 7 + ln * 13) % 200));
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        vid_byte = b;
    endtask

    task automatic send_trc(input logic [7:0] st);
        put(8'hFF); put(8'h00); put(8'h00); put(st);
    endtask

    task automatic body(input int ln, input int n);
        for (int i = 0; i < n; i++) put(pix(ln, i));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) put((i % 2) ? 8'h80 : 8'h10);
    endtask

    task automatic clear_log();
        idle(2);
        ncap = 0;
    endtask

    // checks count, data, and marker placement of a captured line
    task automatic check_line(input int ln, input int exp_n, input bit exp_fs,
                              input string req);
        int bad = 0;
        int extra_ls = 0;
        int extra_fs = 0;
        check(ncap == exp_n, req, "triplet count", ncap, exp_n);
        for (int k = 0; k < exp_n && k < ncap; k++) begin
            if (lcb[k] != pix(ln, 4*k) || ly[k] != pix(ln, 4*k+1) ||
                lcr[k] != pix(ln, 4*k+2)) bad++;
            if (k > 0 && lls[k]) extra_ls++;
            if (k > 0 && lfs[k]) extra_fs++;
        end
        check(bad == 0, "R4", "Cb/Y/Cr mismatches", bad, 0);
        if (ncap > 0) begin
            check(lls[0] == 1'b1 && extra_ls == 0, "R7", "line_start placement",
                  int'(lls[0]) + extra_ls, 1);
            check(lfs[0] == exp_fs && extra_fs == 0, "R8", "field_start placement",
                  int'(lfs[0]) + extra_fs, int'(exp_fs));
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check({trip_valid, line_start, field_start} == 3'b000, "R1",
              "strobes in reset", {trip_valid, line_start, field_start}, 0);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        check({trip_cb, trip_y, trip_cr} == 24'h0 && !trip_valid, "R1",
              "outputs after reset", {trip_cb, trip_y, trip_cr}, 0);
    endtask

    task automatic t_line_no_arm();
        clear_log();
        send_trc(8'h80); body(0, NBYTE); send_trc(8'h9D); idle(8);
        check_line(0, NTRIP, 1'b0, "R5");
    endtask

    task automatic t_field_first();
        clear_log();
        send_trc(8'hB6); idle(6); send_trc(8'hAB); idle(6);
        send_trc(8'h80); body(1, NBYTE); send_trc(8'h9D); idle(8);
        check_line(1, NTRIP, 1'b1, "R8");
    endtask

    task automatic t_second_line();
        clear_log();
        send_trc(8'h80); body(2, NBYTE); send_trc(8'h9D); idle(8);
        check_line(2, NTRIP, 1'b0, "R8");
    endtask

    task automatic t_odd_and_blank();
        clear_log();
        send_trc(8'hC7); body(3, NBYTE); send_trc(8'hDA); idle(8);
        check(ncap == 0, "R3", "odd-field triplets", ncap, 0);
        clear_log();
        send_trc(8'hAB); body(4, NBYTE); send_trc(8'hB6); idle(8);
        check(ncap == 0, "R3", "blanking-line triplets", ncap, 0);
    endtask

    task automatic t_protection();
        // blanking code of previous test armed the field marker
        clear_log();
        send_trc(8'h8E); body(5, NBYTE); send_trc(8'h9D); idle(8);
        check_line(5, NTRIP, 1'b1, "R2");
    endtask

    task automatic t_not_ref();
        clear_log();
        put(8'hFF); put(8'h00); put(8'h00); put(8'h00);
        body(6, 400); idle(8);
        check(ncap == 0, "R2", "triplets without bit 7", ncap, 0);
    endtask

    task automatic t_early_end();
        clear_log();
        send_trc(8'h80); body(7, 10); send_trc(8'h9D); idle(12);
        check_line(7, 2, 1'b0, "R6");
    endtask

    task automatic t_long_line();
        clear_log();
        send_trc(8'h80); body(8, NBYTE + 60); idle(8);
        check_line(8, NTRIP, 1'b0, "R5");
    endtask

    initial begin
        t_reset();
        t_line_no_arm();
        t_field_first();
        t_second_line();
        t_odd_and_blank();
        t_protection();
        t_not_ref();
        t_early_end();
        t_long_line();
        check(hold_err == 0, "R9", "data changes without strobe", hold_err, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule